// File: doc/BRIEF.md
# Shift-Register Clock Divider

This block turns a fast input clock into a slow square wave. It does not use a binary counter. It uses a 14-bit maximal-length shift register with inverted-parity feedback. After reset the register holds a start pattern and advances one step on every input clock. When it holds the terminal pattern, the next edge loads the start pattern again and flips the output level. That edge also raises a pulse that lasts one input cycle. A binary counter needs a carry chain. The shift register does not: each step is a wire shift plus one small parity gate.

The terminal pattern is not a hand-entered constant. It is computed during elaboration by jumping the sequence forward from the start pattern by one less than the half-period length. The half-period is therefore exactly the parameter value. The default is 12500 input cycles, so the division ratio is 25000. Elaboration rejects these cases: an unsupported width, a half-period that does not fit in the sequence, and a start pattern equal to the lock-up pattern. With inverted feedback the lock-up pattern is all ones. With plain parity feedback it is all zeros. The register contents are brought out so that the sequence can be observed.

Top module: `lfsr_clk_div`

## Requirements
- R1: Reset is synchronous and active high. At any edge where `rst` is 1, `state` loads the start pattern, `div_clk` goes to 0 and `tick` goes to 0, all at that same edge.
- R2: After reset is released, the first rise of `div_clk` happens on exactly the HALF_PERIOD-th rising clock edge. The terminal compare uses the full register width.
- R3: `div_clk` holds each level for exactly HALF_PERIOD input clocks. The default HALF_PERIOD is 12500.
- R4: `tick` is 1 for exactly one cycle, and only on the cycle in which `div_clk` has just changed level.
- R5: `state` never equals the lock-up pattern. The lock-up pattern is all ones for inverted feedback, which is the default.
- R6: Outside a reload, state bit i+1 takes the old bit i. Bit 0 takes the inverse of the XOR of the taps. For width 14 the taps are bits 13, 12, 11 and 1. For width 5 the taps are bits 4 and 2. At a reload, `state` equals the start pattern.
- R7: When reset and the terminal match fall on the same edge, reset wins. `div_clk` stays 0, `tick` stays 0 and `state` takes the start pattern.
- R8: With width 5 and HALF_PERIOD 31, one half-period passes through all 31 patterns other than all ones, each exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| div_clk | output | 1 | Divided square-wave output |
| tick | output | 1 | One-cycle pulse on each output level change |
| state | output | WIDTH | Current shift-register contents |

## Verification
Two functions can fall on the same edge: the synchronous reset and the reload on a terminal match. The bench counts edges from reset release. It raises reset so that reset is sampled on exactly the edge at which the first reload would flip the output. It then expects the output low, no pulse, and the start pattern. If the reload won instead, the output would have risen. A reference model of the sequence in the bench is judged on every cycle. A second, 5-bit instance sweeps its full sequence.

// File: rtl/lfsr_div_pkg.sv
package lfsr_div_pkg;

   localparam int MAXW = 32;

   // Zero-based tap positions for the supported widths; zero marks an unsupported width
   function automatic logic [MAXW-1:0] tap_mask(input int w);
      logic [MAXW-1:0] m;
      m = '0;
      case (w)
         4:  begin m[3] = 1'b1; m[2] = 1'b1; end
         5:  begin m[4] = 1'b1; m[2] = 1'b1; end
         8:  begin m[7] = 1'b1; m[5] = 1'b1; m[4] = 1'b1; m[3] = 1'b1; end
         14: begin m[13] = 1'b1; m[12] = 1'b1; m[11] = 1'b1; m[1] = 1'b1; end
         16: begin m[15] = 1'b1; m[14] = 1'b1; m[12] = 1'b1; m[3] = 1'b1; end
         default: m = '0;
      endcase
      return m;
   endfunction

   // Jump the sequence forward by n steps using powers of the step matrix.
   // The inverted form is the complement of the plain form when the tap count is even.
   function automatic logic [MAXW-1:0] lfsr_jump(input logic [MAXW-1:0] s,
                                                 input int unsigned n,
                                                 input int w,
                                                 input logic inv);
      logic [MAXW-1:0][MAXW-1:0] m;
      logic [MAXW-1:0][MAXW-1:0] sq;
      logic [MAXW-1:0] y;
      logic [MAXW-1:0] t;
      logic [MAXW-1:0] wmask;
      int unsigned     left;
      wmask = (w >= MAXW) ? '1 : ((MAXW'(1) << w) - MAXW'(1));
      y     = inv ? (~s & wmask) : (s & wmask);
      m     = '0;
      m[0]  = tap_mask(w);
      for (int i = 1; i < w; i++) m[i] = MAXW'(1) << (i - 1);
      left = n;
      while (left != 0) begin
         if ((left & 1) != 0) begin
            t = '0;
            for (int i = 0; i < w; i++) t[i] = ^(m[i] & y);
            y = t;
         end
         sq = '0;
         for (int i = 0; i < w; i++)
            for (int k = 0; k < w; k++)
               if (m[i][k]) sq[i] = sq[i] ^ m[k];
         m = sq;
         left = left >> 1;
      end
      return inv ? (~y & wmask) : y;
   endfunction

endpackage

// File: rtl/lfsr_div_core.sv
module lfsr_div_core #(
   parameter int          W       = 14,
   parameter int          HALF    = 12500,
   parameter logic [W-1:0] START  = '0,
   parameter bit          XNOR_FB = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   output logic [W-1:0] q,
   output logic         match
);
   localparam logic [W-1:0] TAPS = W'(lfsr_div_pkg::tap_mask(W));
   localparam logic [W-1:0] LOCK = XNOR_FB ? '1 : '0;
   localparam logic [W-1:0] TERM =
      W'(lfsr_div_pkg::lfsr_jump(lfsr_div_pkg::MAXW'(START), HALF - 1, W, XNOR_FB));

   if (W < 2 || W > lfsr_div_pkg::MAXW) begin : g_bad_width
      $error("lfsr_div_core: width out of range");
   end
   if (TAPS == '0) begin : g_no_taps
      $error("lfsr_div_core: no maximal tap set for this width");
   end
   if (HALF < 2 || longint'(HALF) > (longint'(1) << W) - 1) begin : g_bad_half
      $error("lfsr_div_core: half-period must lie in 2 .. 2**W-1");
   end
   if (START == LOCK) begin : g_bad_start
      $error("lfsr_div_core: start pattern equals the lock-up pattern");
   end

   logic fb;
   if (XNOR_FB) begin : g_fb_inv
      assign fb = ~(^(q & TAPS));
   end else begin : g_fb_plain
      assign fb = ^(q & TAPS);
   end

   assign match = (q == TERM);

   always_ff @(posedge clk) begin
      if (rst)        q <= START;
      else if (match) q <= START;
      else            q <= {q[W-2:0], fb};
   end

   p_no_lockup_r5: assert property (@(posedge clk) disable iff (rst) q != LOCK)
      else $error("lock-up pattern reached");
   p_reload_r6: assert property (@(posedge clk) disable iff (rst) match |=> q == START)
      else $error("reload did not restore start pattern");
   p_shift_r6: assert property (@(posedge clk) disable iff (rst)
                                !match |=> q[W-1:1] == $past(q[W-2:0]))
      else $error("register did not shift");
endmodule

// File: rtl/lfsr_div_out.sv
module lfsr_div_out (
   input  logic clk,
   input  logic rst,
   input  logic match,
   output logic div_clk,
   output logic tick
);
   always_ff @(posedge clk) begin
      if (rst) begin
         div_clk <= 1'b0;
         tick    <= 1'b0;
      end else begin
         tick <= match;
         if (match) div_clk <= ~div_clk;
      end
   end

   p_reset_r1: assert property (@(posedge clk) rst |=> (!div_clk && !tick))
      else $error("output not cleared by reset");
   p_pulse_r4: assert property (@(posedge clk) disable iff (rst) tick |=> !tick)
      else $error("pulse longer than one cycle");
   p_edge_r4: assert property (@(posedge clk) disable iff (rst)
                               (div_clk != $past(div_clk)) |-> tick)
      else $error("level change without pulse");
endmodule

// File: rtl/lfsr_clk_div.sv
module lfsr_clk_div #(
   parameter int               WIDTH       = 14,
   parameter int               HALF_PERIOD = 12500,
   parameter logic [WIDTH-1:0] START       = '0,
   parameter bit               XNOR_FB     = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   output logic             div_clk,
   output logic             tick,
   output logic [WIDTH-1:0] state
);
   logic match;

   lfsr_div_core #(
      .W      (WIDTH),
      .HALF   (HALF_PERIOD),
      .START  (START),
      .XNOR_FB(XNOR_FB)
   ) i_core (
      .clk  (clk),
      .rst  (rst),
      .q    (state),
      .match(match)
   );

   lfsr_div_out i_out (
      .clk    (clk),
      .rst    (rst),
      .match  (match),
      .div_clk(div_clk),
      .tick   (tick)
   );
endmodule

// File: tb/test_lfsr_clk_div.sv
module div_scoreboard #(
   parameter int           W     = 14,
   parameter int           HALF  = 12500,
   parameter logic [W-1:0] START = '0,
   parameter logic [W-1:0] TAPS  = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] state,
   input  logic         div_clk,
   input  logic         tick,
   output int           checks,
   output int           fails
);
   logic         rst_seen;
   logic         started;
   logic [W-1:0] m_st;
   logic         m_div, m_tick, prev_div, first;
   int           k, since;

   initial begin
      checks = 0; fails = 0; started = 1'b0;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(posedge clk) rst_seen <= rst;

   always @(negedge clk) begin
      if (rst_seen === 1'b1) begin
         m_st = START; m_div = 1'b0; m_tick = 1'b0; k = 0; since = 0;
         prev_div = 1'b0; first = 1'b1; started = 1'b1;
         chk(state == START, "R1", "reset state", longint'(state), longint'(START));
         chk(div_clk == 1'b0, "R1", "reset div_clk", longint'(div_clk), 0);
         chk(tick == 1'b0, "R1", "reset tick", longint'(tick), 0);
      end else if (started) begin
         if (k == HALF - 1) begin
            m_st = START; m_div = ~m_div; m_tick = 1'b1; k = 0;
         end else begin
            m_st = {m_st[W-2:0], ~(^(m_st & TAPS))}; m_tick = 1'b0; k++;
         end
         since++;
         chk(state == m_st, "R6", "state", longint'(state), longint'(m_st));
         chk(state != '1, "R5", "lock-up pattern", longint'(state), 0);
         chk(div_clk == m_div, "R3", "div_clk", longint'(div_clk), longint'(m_div));
         chk(tick == m_tick, "R4", "tick", longint'(tick), longint'(m_tick));
         if (div_clk != prev_div) begin
            if (first) chk(since == HALF, "R2", "first rise edge", since, HALF);
            else       chk(since == HALF, "R3", "half-period", since, HALF);
            since = 0; first = 1'b0;
         end
         prev_div = div_clk;
      end
   end
endmodule

module test_lfsr_clk_div;
   localparam int HALF = 12500;

   logic        clk = 1'b0;
   logic        rst, rst_s;
   logic        div_clk, tick, div_s, tick_s;
   logic [13:0] state;
   logic [4:0]  state_s;
   int          own_checks = 0, own_fails = 0;
   int          ca, fa, cb, fb;
   bit          done_a = 0, done_b = 0;

   always #5 clk = ~clk;

   lfsr_clk_div i_lfsr_clk_div (
      .clk(clk), .rst(rst), .div_clk(div_clk), .tick(tick), .state(state));

   lfsr_clk_div #(.WIDTH(5), .HALF_PERIOD(31), .START(5'h00)) i_lfsr_clk_div_small (
      .clk(clk), .rst(rst_s), .div_clk(div_s), .tick(tick_s), .state(state_s));

   div_scoreboard #(.W(14), .HALF(HALF), .START(14'h0000), .TAPS(14'h3802)) i_sb_a (
      .clk(clk), .rst(rst), .state(state), .div_clk(div_clk), .tick(tick),
      .checks(ca), .fails(fa));

   div_scoreboard #(.W(5), .HALF(31), .START(5'h00), .TAPS(5'h14)) i_sb_b (
      .clk(clk), .rst(rst_s), .state({9'd0, state_s}), .div_clk(div_s), .tick(tick_s),
      .checks(cb), .fails(fb));

   task automatic own(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      own_checks++;
      if (!ok) begin
         own_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic report();
      int total, bad;
      total = own_checks + ca + cb;
      bad   = own_fails + fa + fb;
      $display("%0d/%0d checks passed", total - bad, total);
      $finish;
   endtask

   // Main instance: collision of reset with the first reload (R7), then long run
   initial begin
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      repeat (HALF - 1) @(negedge clk);
      own(div_clk == 1'b0, "R7", "div_clk before collision", longint'(div_clk), 0);
      rst = 1'b1;
      @(negedge clk);
      own(div_clk == 1'b0, "R7", "div_clk after collision", longint'(div_clk), 0);
      own(tick == 1'b0, "R7", "tick after collision", longint'(tick), 0);
      own(state == 14'h0000, "R7", "state after collision", longint'(state), 0);
      rst = 1'b0;
      repeat (4 * HALF + 20) @(negedge clk);
      done_a = 1;
   end

   // Small instance: full-sequence sweep (R8)
   initial begin
      logic [31:0] seen;
      int          dup;
      rst_s = 1'b1;
      repeat (2) @(negedge clk);
      rst_s = 1'b0;
      repeat (31) @(negedge clk);
      seen = '0; dup = 0;
      for (int i = 0; i < 31; i++) begin
         if (seen[state_s]) dup++;
         seen[state_s] = 1'b1;
         @(negedge clk);
      end
      own(dup == 0, "R8", "repeated patterns", dup, 0);
      own($countones(seen) == 31, "R8", "distinct patterns", $countones(seen), 31);
      own(seen[31] == 1'b0, "R8", "all-ones visited", longint'(seen[31]), 0);
      repeat (100) @(negedge clk);
      done_b = 1;
   end

   initial begin
      fork
         begin
            wait (done_a && done_b);
         end
         begin
            repeat (200000) @(posedge clk);
            own(1'b0, "watchdog", "run did not finish", 0, 1);
         end
      join_any
      report();
   end
endmodule